// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Threshold

This block buffers bytes coming out of a serial-bus byte receiver until a register read port takes them. The receiver raises a one-cycle valid strobe with each byte; the read side pops one byte per strobe and sees it on a registered data output in the following cycle. Bytes leave in the order they arrived.

Software programs a zero-based threshold: writing N-1 makes the fill event rise once N bytes are held. The event is presented as a level and also as bit 3 of an 8-bit event vector. A zero-based occupancy value, a status byte that merges the queue's empty/full flags with two transmit-side flags passed in from outside, and a sticky overflow flag complete the outputs. A flush input empties the queue, clears the overflow flag and returns the threshold to zero.

Top module: `rxq_wm_top`

## Requirements
- R1: After reset the queue is empty, occupancy reads 0, threshold is 0, the fill event, overflow flag and read data are all 0, and status bit 6 is 1.
- R2: A pop of a non-empty queue presents the oldest stored byte on `rd_data` after the next rising edge; bytes come out in arrival order and `rd_data` holds its value between pops.
- R3: A byte strobed in while 16 bytes are held (judged before any same-cycle pop) is dropped, and `overflow` becomes 1 and stays 1 until flush or reset.
- R4: A pop of an empty queue changes no stored state except that `rd_data` becomes 0.
- R5: `occupancy` equals the number of stored bytes minus one when at least one byte is held, and 0 when empty.
- R6: Status bit 6 is 1 exactly when no byte is held; status bit 5 is 1 exactly when 16 bytes are held.
- R7: Status bit 7 copies `tx_empty_in`, status bit 4 copies `tx_full_in`, and status bits 3..0 are 0.
- R8: After a threshold write of value V, `wm_event` is 1 exactly while more than V bytes are held; `irq_vec` bit 3 equals `wm_event` and its other bits are 0.
- R9: A flush empties the queue, sets the threshold to 0, clears `overflow` and `rd_data`, and overrides a push, pop or threshold write in the same cycle.
- R10: A push and a pop in the same cycle on a queue holding between 1 and 15 bytes leave the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the receiver |
| in_byte | input | 8 | Received byte |
| pop | input | 1 | Read strobe from the register port |
| wm_wr | input | 1 | Threshold write strobe |
| wm_val | input | 4 | Zero-based threshold value |
| flush | input | 1 | Empty queue and restore defaults |
| tx_empty_in | input | 1 | Transmit-side empty flag, passed into status |
| tx_full_in | input | 1 | Transmit-side full flag, passed into status |
| rd_data | output | 8 | Byte returned by the last pop |
| occupancy | output | 4 | Stored bytes minus one (0 when empty) |
| status | output | 8 | Merged status byte |
| wm_event | output | 1 | Fill threshold reached |
| irq_vec | output | 8 | Event vector, fill event on bit 3 |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The hardest situation to reach is a push arriving while all 16 slots are full, especially together with a pop in the same cycle, since random traffic with balanced push and pop rates rarely fills the queue. The stimulus biases alternate random phases toward pushes and away from pops so the queue repeatedly saturates, and a directed sequence fills it to 16 and then strobes both a lone push and a push-with-pop. A second directed case drains to empty and pops again, and flush is issued together with push, pop and threshold writes to exercise its priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ST_TX_EMPTY = 7;
    localparam int ST_RX_EMPTY = 6;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_TX_FULL  = 4;
    localparam int EV_RX_FILL  = 3;
    localparam int ST_W        = 8;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_addr] <= wr_data;
    end

    assign rd_word = slot_q[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic          pop,
    input  logic          wm_wr,
    input  logic [AW-1:0] wm_val,
    input  logic          flush,
    input  logic [DW-1:0] head_word,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic [AW-1:0] wm,
    output logic          overflow,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [AW-1:0] wm;
        logic          ovf;
        logic [DW-1:0] rd_data;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic full_now, empty_now, do_push, do_pop;

    always_comb begin
        st_d      = st_q;
        full_now  = (st_q.count == CW'(DEPTH));
        empty_now = (st_q.count == '0);
        do_push   = in_valid && !full_now && !flush;
        do_pop    = pop && !empty_now && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (pop) st_d.rd_data = do_pop ? head_word : '0;
            if (do_pop) st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            if (do_push) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
            if (in_valid && full_now) st_d.ovf = 1'b1;
            st_d.count = st_q.count + CW'(do_push) - CW'(do_pop);
            if (wm_wr) st_d.wm = wm_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en    = do_push;
    assign wr_addr  = st_q.wr_ptr;
    assign wr_data  = in_byte;
    assign rd_addr  = st_q.rd_ptr;
    assign count    = st_q.count;
    assign wm       = st_q.wm;
    assign overflow = st_q.ovf;
    assign rd_data  = st_q.rd_data;

    // Dropped byte leaves the queue full and raises the sticky flag
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pop && !flush && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && overflow));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !in_valid && !flush && count == '0) |=> (count == '0 && rd_data == '0 && $stable(rd_addr)));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && wm == '0 && !overflow && rd_data == '0));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_balanced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pop && !flush && count != '0 && count != CW'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   count,
    input  logic [AW-1:0]   wm,
    input  logic            tx_empty_in,
    input  logic            tx_full_in,
    output logic [AW-1:0]   occupancy,
    output logic [ST_W-1:0] status,
    output logic            wm_event,
    output logic [ST_W-1:0] irq_vec
);
    logic is_empty, is_full;

    always_comb begin
        is_empty  = (count == '0);
        is_full   = (count == CW'(DEPTH));
        occupancy = is_empty ? '0 : AW'(count - 1'b1);
        wm_event  = (count > CW'(wm));
        status    = '0;
        status[ST_TX_EMPTY] = tx_empty_in;
        status[ST_RX_EMPTY] = is_empty;
        status[ST_RX_FULL]  = is_full;
        status[ST_TX_FULL]  = tx_full_in;
        irq_vec   = '0;
        irq_vec[EV_RX_FILL] = wm_event;
    end

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_RX_EMPTY] && status[ST_RX_FULL]));

    assert_no_event_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RX_EMPTY] |-> !irq_vec[EV_RX_FILL]);

    assert_full_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RX_FULL] |-> wm_event);
endmodule

// File: rtl/rxq_wm_top.sv
module rxq_wm_top #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic          pop,
    input  logic          wm_wr,
    input  logic [AW-1:0] wm_val,
    input  logic          flush,
    input  logic          tx_empty_in,
    input  logic          tx_full_in,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] occupancy,
    output logic [7:0]    status,
    output logic          wm_event,
    output logic [7:0]    irq_vec,
    output logic          overflow
);
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr, wm;
    logic [DW-1:0] wr_data, head_word;
    logic [CW-1:0] count;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_word(head_word)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .pop(pop), .wm_wr(wm_wr), .wm_val(wm_val), .flush(flush),
        .head_word(head_word), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .count(count), .wm(wm),
        .overflow(overflow), .rd_data(rd_data)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .count(count), .wm(wm),
        .tx_empty_in(tx_empty_in), .tx_full_in(tx_full_in),
        .occupancy(occupancy), .status(status), .wm_event(wm_event),
        .irq_vec(irq_vec)
    );
endmodule

// File: tb/tb_rxq_wm_top.sv
`timescale 1ns/1ps
module tb_rxq_wm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, pop = 1'b0, wm_wr = 1'b0, flush = 1'b0;
    logic [7:0] in_byte = '0;
    logic [3:0] wm_val = '0;
    logic       tx_empty_in = 1'b0, tx_full_in = 1'b0;
    logic [7:0] rd_data, status, irq_vec;
    logic [3:0] occupancy;
    logic       wm_event, overflow;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] mq[$];
    int         m_wm = 0;
    bit         m_ovf = 0;
    logic [7:0] m_rd = '0;
    bit         last_pop_empty = 0;

    always #4 clk = ~clk;

    rxq_wm_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .pop(pop), .wm_wr(wm_wr), .wm_val(wm_val), .flush(flush),
        .tx_empty_in(tx_empty_in), .tx_full_in(tx_full_in),
        .rd_data(rd_data), .occupancy(occupancy), .status(status),
        .wm_event(wm_event), .irq_vec(irq_vec), .overflow(overflow)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_occ();
        return (mq.size() == 0) ? 0 : mq.size() - 1;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s = '0;
        s[7] = tx_empty_in;
        s[6] = (mq.size() == 0);
        s[5] = (mq.size() == 16);
        s[4] = tx_full_in;
        return s;
    endfunction

    function automatic bit exp_ev();
        return mq.size() > m_wm;
    endfunction

    task automatic model_step();
        int pre;
        if (flush) begin
            mq.delete(); m_wm = 0; m_ovf = 0; m_rd = '0;
            return;
        end
        pre = mq.size();
        last_pop_empty = 0;
        if (pop) begin
            if (pre > 0) m_rd = mq.pop_front();
            else begin m_rd = '0; last_pop_empty = 1; end
        end
        if (in_valid) begin
            if (pre < 16) mq.push_back(in_byte);
            else m_ovf = 1;
        end
        if (wm_wr) m_wm = wm_val;
    endtask

    task automatic check_all();
        chk("R5 occupancy", occupancy, exp_occ());
        chk("R6 status empty/full", {status[6], status[5]}, {exp_status()[6], exp_status()[5]});
        chk("R7 status pass-through", {status[7], status[4], status[3:0]},
            {exp_status()[7], exp_status()[4], exp_status()[3:0]});
        chk("R8 wm_event", wm_event, exp_ev());
        chk("R8 irq_vec", irq_vec, {4'b0, exp_ev(), 3'b0});
        chk("R3 overflow", overflow, m_ovf);
        chk(last_pop_empty ? "R4 empty pop data" : "R2 read data", rd_data, m_rd);
    endtask

    // drive at negedge, step one edge, check at next negedge
    task automatic cyc(input bit v, input logic [7:0] b, input bit p,
                       input bit ww, input logic [3:0] wv, input bit f);
        in_valid = v; in_byte = b; pop = p; wm_wr = ww; wm_val = wv; flush = f;
        @(posedge clk);
        model_step();
        @(negedge clk);
        in_valid = 0; pop = 0; wm_wr = 0; flush = 0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'h5eed_0417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 occupancy", occupancy, 0);
        chk("R1 status", status, 8'h40);
        chk("R1 wm_event", wm_event, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 rd_data", rd_data, 0);

        // R4 pop on empty
        cyc(0, 8'h00, 1, 0, 0, 0);
        chk("R4 still empty", status[6], 1);

        // fill to 16 in order, threshold 3 -> event at 4 bytes (R8)
        cyc(0, 8'h00, 0, 1, 4'd3, 0);
        for (int i = 0; i < 16; i++) begin
            cyc(1, 8'hA0 + 8'(i), 0, 0, 0, 0);
            chk("R8 threshold N-1", wm_event, (i + 1) >= 4);
        end
        chk("R6 full bit", status[5], 1);
        // R3 push into full queue, alone and with pop
        cyc(1, 8'hEE, 0, 0, 0, 0);
        chk("R3 dropped sticky", overflow, 1);
        cyc(1, 8'hEF, 1, 0, 0, 0);
        chk("R2 first byte out", rd_data, 8'hA0);
        // R10 balanced push/pop at 15 bytes
        c0 = occupancy;
        cyc(1, 8'h11, 1, 0, 0, 0);
        chk("R10 count kept", occupancy, c0);
        // drain: R2 order
        while (mq.size() > 0) cyc(0, 8'h00, 1, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, 0, 0);
        chk("R4 empty pop zero", rd_data, 0);
        // R9 flush with push, pop and wm write in same cycle
        cyc(1, 8'h55, 0, 0, 0, 0);
        cyc(1, 8'h66, 1, 1, 4'd9, 1);
        chk("R9 flush empty", status[6], 1);
        chk("R9 flush ovf", overflow, 0);
        cyc(1, 8'h77, 0, 0, 0, 0);
        chk("R9 wm back to 0", wm_event, 1);

        // random phases, alternately biased toward filling
        for (int ph = 0; ph < 12; ph++) begin
            int pp = (ph % 2) ? 80 : 45;
            int pq = (ph % 2) ? 20 : 50;
            for (int k = 0; k < 300; k++) begin
                tx_empty_in = 1'($urandom_range(0, 1));
                tx_full_in  = 1'($urandom_range(0, 1));
                cyc(($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < pq,
                    ($urandom % 100) < 4, 4'($urandom), ($urandom % 1000) < 5);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule